// File: doc/BRIEF.md
# SPI Register Access Target

This block is an SPI target, clocked by the system clock, that exposes a small byte-wide register file to an external master. Every chip-select frame opens with a command header: the register address, followed by a single direction bit. After the header come data bytes. In a write frame the bytes are stored. In a read frame the bytes are shifted back to the master. The address steps up by one after each byte, so one frame can carry a burst of any length.

Three static configuration inputs choose the frame shape:
- `cfg_addr2b` selects a 15-bit address (16-clock header) or a 7-bit address (8-clock header).
- `cfg_lsb_first` selects the bit order of the address and data fields.
- `cfg_3wire` selects either a separate input and output pin, or one shared data pin that turns around after the direction bit.

The pad ring builds the shared pin from `spi_sdio_i`, `spi_sdio_o` and `spi_sdio_oe`.

SPI mode 0 is used. The pins are synchronised into the system clock domain, and rising and falling SCLK edges are detected there. The controller is a four-state machine:
- IDLE: waits for chip select. When CS goes active, it moves to HDR.
- HDR: collects the address and direction bits. After the last header bit it moves to WDATA if the direction bit is 0, or to RDATA if it is 1.
- WDATA: assembles bytes and writes each complete one.
- RDATA: drives one read bit per falling edge.

CS going inactive moves any state back to IDLE.

Top module: `spi_reg_target`

## Requirements
- R1: After reset both output enables are low and every register reads back as 0x00.
- R2: With `cfg_addr2b`=1 the header is 15 address bits then the direction bit (1 = read, 0 = write), 16 SCLK rising edges in all.
- R3: With `cfg_addr2b`=0 the header is 7 address bits then the direction bit, 8 rising edges in all.
- R4: With `cfg_lsb_first`=0 the address is sent from its top bit down to bit 0 and data from bit 7 down to bit 0. With `cfg_lsb_first`=1 both fields are sent bit 0 first. The direction bit is last in either order.
- R5: Each further byte in a frame uses the previous address plus one, for reads and for writes. The register index is the address modulo DEPTH, so index DEPTH-1 is followed by index 0.
- R6: Inputs are sampled on rising SCLK and outputs change on falling SCLK. The first read bit is driven after the falling edge that follows the direction bit.
- R7: If CS rises while the last write byte is incomplete, that byte is discarded.
- R8: CS going inactive at any point ends the frame. The active output enable drops within SYNC_STAGES+2 system clocks, and the next frame starts with a fresh header.
- R9: With `cfg_3wire`=0, input is taken from `spi_sdi` and read data leaves on `spi_sdo` with `spi_sdo_oe`. `spi_sdi` is ignored during read data, and `spi_sdio_oe` stays low.
- R10: With `cfg_3wire`=1, input is taken from `spi_sdio_i` and `spi_sdi` is ignored. Read data leaves on `spi_sdio_o` with `spi_sdio_oe`, and `spi_sdo_oe` stays low.
- R11: Both output enables stay low during the header and throughout write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr2b | input | 1 | 1: 15-bit address, 0: 7-bit address |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_3wire | input | 1 | 1: shared data pin, 0: separate pins |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_sdi | input | 1 | Serial data in (4-wire) |
| spi_sdio_i | input | 1 | Shared pin input value (3-wire) |
| spi_sdo | output | 1 | Serial data out (4-wire) |
| spi_sdo_oe | output | 1 | Drive enable for spi_sdo |
| spi_sdio_o | output | 1 | Shared pin output value (3-wire) |
| spi_sdio_oe | output | 1 | Drive enable for the shared pin |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- A burst that starts at the top register index must wrap to index 0. A design that wraps wrongly would write into a register that does not exist.
- A write frame that ends with a partial byte must leave that register at 0x00. A design that stored partial bytes would write a shifted fragment.
- A read that is cut short by CS must release the drive enable. A design that missed this would hold the drive enable after the abort.
- A scrambled pattern is driven on the unused input in every mode. A design that listened to that pin would pick up wrong addresses and data.
- Each frame shape is read back in its own bit order. A design with the header length or the position of the direction bit wrong would return data from the wrong register, or would never drive.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_WDATA,
        ST_RDATA
    } spi_st_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int            W       = 4,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    // STAGES flops synchronise, one more holds the previous value for edge detection
    logic [W-1:0] pipe [STAGES+1];

    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q      = pipe[STAGES-1];
    assign q_prev = pipe[STAGES];
endmodule

// File: rtl/spi_reg_mem.sv
module spi_reg_mem #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we) begin
            regs[addr] <= wdata;
        end
    end

    assign rdata = regs[addr];
endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target #(
    parameter int DEPTH       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_addr2b,
    input  logic cfg_lsb_first,
    input  logic cfg_3wire,
    input  logic spi_cs_n,
    input  logic spi_sclk,
    input  logic spi_sdi,
    input  logic spi_sdio_i,
    output logic spi_sdo,
    output logic spi_sdo_oe,
    output logic spi_sdio_o,
    output logic spi_sdio_oe
);
    import spi_reg_pkg::*;

    localparam int AW     = $clog2(DEPTH);
    localparam int ADDR_W = 15;
    localparam int CNT_W  = 5;

    // ---------------- pin synchronisation ----------------
    logic [3:0] pin_q, pin_p;
    spi_pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   ({spi_cs_n, spi_sclk, spi_sdi, spi_sdio_i}),
        .q      (pin_q),
        .q_prev (pin_p)
    );

    logic cs_q, sclk_rise, sclk_fall, din;
    assign cs_q      = pin_q[3];
    assign sclk_rise =  pin_q[2] & ~pin_p[2];
    assign sclk_fall = ~pin_q[2] &  pin_p[2];
    assign din       = cfg_3wire ? pin_q[0] : pin_q[1];

    // ---------------- state and datapath registers ----------------
    spi_st_e             state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [7:0]          wsh_q;
    logic                dout_q, oe_q;

    logic [CNT_W-1:0]    hdr_len;
    logic                hdr_last;
    logic [2:0]          byte_bit, rd_sel;
    logic [7:0]          wnext, rdata;
    logic                mem_we;

    assign hdr_len  = cfg_addr2b ? CNT_W'(16) : CNT_W'(8);
    assign hdr_last = (cnt_q == hdr_len - CNT_W'(1));
    assign byte_bit = cnt_q[2:0];
    assign rd_sel   = cfg_lsb_first ? byte_bit : 3'd7 - byte_bit;
    assign wnext    = cfg_lsb_first ? {din, wsh_q[7:1]} : {wsh_q[6:0], din};
    assign mem_we   = (state_q == ST_WDATA) && !cs_q && sclk_rise && (byte_bit == 3'd7);

    spi_reg_mem #(.DEPTH(DEPTH), .DW(8)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (addr_q[AW-1:0]),
        .wdata (wnext),
        .rdata (rdata)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (cs_q) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_HDR;
                ST_HDR:   if (sclk_rise && hdr_last) state_d = din ? ST_RDATA : ST_WDATA;
                ST_WDATA: state_d = ST_WDATA;
                ST_RDATA: state_d = ST_RDATA;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
            wsh_q  <= '0;
            dout_q <= 1'b0;
            oe_q   <= 1'b0;
        end else if (cs_q || state_q == ST_IDLE) begin
            cnt_q  <= '0;
            addr_q <= '0;
            wsh_q  <= '0;
            oe_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_HDR: if (sclk_rise) begin
                    if (hdr_last) begin
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (cfg_lsb_first) addr_q[cnt_q[3:0]] <= din;
                        else               addr_q <= {addr_q[ADDR_W-2:0], din};
                    end
                end
                ST_WDATA: if (sclk_rise) begin
                    wsh_q <= wnext;
                    cnt_q <= {2'b00, byte_bit + 3'd1};
                    if (byte_bit == 3'd7) addr_q <= addr_q + ADDR_W'(1);
                end
                ST_RDATA: if (sclk_fall) begin
                    dout_q <= rdata[rd_sel];
                    oe_q   <= 1'b1;
                    cnt_q  <= {2'b00, byte_bit + 3'd1};
                    if (byte_bit == 3'd7) addr_q <= addr_q + ADDR_W'(1);
                end
                default: ;
            endcase
        end
    end

    assign spi_sdo     = dout_q;
    assign spi_sdio_o  = dout_q;
    assign spi_sdo_oe  = oe_q & ~cfg_3wire;
    assign spi_sdio_oe = oe_q &  cfg_3wire;

    // ---------------- assertions ----------------
    AST_HDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HDR |-> cnt_q < hdr_len); // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> addr_q == $past(addr_q) + ADDR_W'(1)); // R5
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |=> !(spi_sdo_oe || spi_sdio_oe)); // R8
    AST_NO_DRIVE_OUTSIDE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_RDATA |-> !(spi_sdo_oe || spi_sdio_oe)); // R11
    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sdo_oe || spi_sdio_oe) |-> $past(sclk_fall)); // R6
endmodule

// File: tb/sim_spi_reg_target.sv
module sim_spi_reg_target;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_addr2b = 1'b1, cfg_lsb_first = 1'b0, cfg_3wire = 1'b0;
    logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_sdi = 1'b0, spi_sdio_i = 1'b0;
    logic spi_sdo, spi_sdo_oe, spi_sdio_o, spi_sdio_oe;

    always #2.5 clk = ~clk;

    spi_reg_target u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr2b(cfg_addr2b), .cfg_lsb_first(cfg_lsb_first), .cfg_3wire(cfg_3wire),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_sdi(spi_sdi), .spi_sdio_i(spi_sdio_i),
        .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .spi_sdio_o(spi_sdio_o), .spi_sdio_oe(spi_sdio_oe)
    );

    int n_vec = 0, n_bad = 0;
    logic [7:0] exp_mem [64];
    logic junk = 1'b0;
    logic pin_oe, other_oe;

    // {3wire, lsb_first, addr2b, addr[14:0], byte0, byte1}
    localparam logic [33:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b1, 15'h0012, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 1'b1, 15'h4025, 8'h81, 8'h7E},
        {1'b0, 1'b0, 1'b0, 15'h0030, 8'h0F, 8'hF0},
        {1'b1, 1'b0, 1'b1, 15'h0008, 8'h5A, 8'hC3},
        {1'b1, 1'b1, 1'b0, 15'h003F, 8'h12, 8'h34},
        {1'b0, 1'b1, 1'b0, 15'h0011, 8'h96, 8'h69}
    };

    task automatic check(input logic ok, input string req, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic xfer(input logic b, output logic r);
        junk = ~junk ^ b;
        if (cfg_3wire) begin spi_sdio_i = b; spi_sdi = junk; end
        else           begin spi_sdi = b; spi_sdio_i = junk; end
        repeat (8) @(negedge clk);
        r        = cfg_3wire ? spi_sdio_o  : spi_sdo;
        pin_oe   = cfg_3wire ? spi_sdio_oe : spi_sdo_oe;
        other_oe = cfg_3wire ? spi_sdo_oe  : spi_sdio_oe;
        spi_sclk = 1'b1;
        repeat (8) @(negedge clk);
        spi_sclk = 1'b0;
    endtask

    task automatic frame_start();
        spi_cs_n = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic frame_end();
        repeat (8) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic header(input logic [14:0] a, input logic rw, output logic oe_seen);
        int ab = cfg_addr2b ? 15 : 7;
        logic r;
        oe_seen = 1'b0;
        for (int i = 0; i < ab; i++) begin
            xfer(cfg_lsb_first ? a[i] : a[ab-1-i], r);
            oe_seen |= pin_oe | other_oe;
        end
        xfer(rw, r);
        oe_seen |= pin_oe | other_oe;
    endtask

    task automatic send_byte(input logic [7:0] d, input int nbits, inout logic oe_seen);
        logic r;
        for (int k = 0; k < nbits; k++) begin
            xfer(cfg_lsb_first ? d[k] : d[7-k], r);
            oe_seen |= pin_oe | other_oe;
        end
    endtask

    task automatic recv_byte(output logic [7:0] d, output logic oe_ok);
        logic r;
        oe_ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            xfer(junk, r);
            if (cfg_lsb_first) d[k] = r; else d[7-k] = r;
            if (!(pin_oe && !other_oe)) oe_ok = 1'b0;
        end
    endtask

    task automatic wr_frame(input logic [14:0] a, input logic [7:0] d0, input logic [7:0] d1,
                            input int bits1, output logic oe_seen);
        frame_start();
        header(a, 1'b0, oe_seen);
        send_byte(d0, 8, oe_seen);
        exp_mem[a[5:0]] = d0;
        send_byte(d1, bits1, oe_seen);
        if (bits1 == 8) exp_mem[6'(a[5:0] + 6'd1)] = d1;
        frame_end();
    endtask

    task automatic rd_frame(input logic [14:0] a, input string tag0, input string tag1,
                            input string oetag);
        logic [7:0] d;
        logic oe_ok, hdr_oe;
        frame_start();
        header(a, 1'b1, hdr_oe);
        check(!hdr_oe, "R11", hdr_oe, 0);
        recv_byte(d, oe_ok);
        check(d == exp_mem[a[5:0]], tag0, d, exp_mem[a[5:0]]);
        check(oe_ok, oetag, oe_ok, 1);
        recv_byte(d, oe_ok);
        check(d == exp_mem[6'(a[5:0] + 6'd1)], tag1, d, exp_mem[6'(a[5:0] + 6'd1)]);
        frame_end();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic oe_seen;
        logic [7:0] d;
        logic oe_ok;
        for (int i = 0; i < 64; i++) exp_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        check(!spi_sdo_oe && !spi_sdio_oe, "R1 oe", {spi_sdo_oe, spi_sdio_oe}, 0);
        rd_frame(15'h0001, "R1", "R1", "R9");

        // table of vectors: write two bytes, read them back
        for (int v = 0; v < 6; v++) begin
            logic [33:0] e = VEC[v];
            cfg_3wire = e[33]; cfg_lsb_first = e[32]; cfg_addr2b = e[31];
            repeat (4) @(negedge clk);
            wr_frame(e[30:16], e[15:8], e[7:0], 8, oe_seen);
            check(!oe_seen, "R11", oe_seen, 0);
            rd_frame(e[30:16],
                     cfg_addr2b ? "R2 R4 R6" : "R3 R4 R6",
                     "R5",
                     cfg_3wire ? "R10" : "R9");
        end
        // R5: wrap from index 63 to 0 (row 4 wrote 0x34 into index 0)
        cfg_3wire = 1'b0; cfg_lsb_first = 1'b0; cfg_addr2b = 1'b1;
        repeat (4) @(negedge clk);
        rd_frame(15'h0000, "R5 wrap", "R5", "R9");

        // R7: partial last byte discarded
        wr_frame(15'h0020, 8'hAA, 8'h55, 5, oe_seen);
        rd_frame(15'h0020, "R7", "R7", "R9");

        // R8: abort a read, enables drop, next frame works
        frame_start();
        header(15'h0012, 1'b1, oe_seen);
        recv_byte(d, oe_ok);
        spi_cs_n = 1'b1;
        repeat (6) @(negedge clk);
        check(!spi_sdo_oe && !spi_sdio_oe, "R8", {spi_sdo_oe, spi_sdio_oe}, 0);
        repeat (8) @(negedge clk);
        rd_frame(15'h0012, "R8", "R8", "R9");

        // R10: 3-wire read after 4-wire traffic, sdi scrambled throughout
        cfg_3wire = 1'b1;
        repeat (4) @(negedge clk);
        rd_frame(15'h0008, "R10", "R10", "R10");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule